// File: doc/BRIEF.md
# Channel-Routed Mailbox Dispatcher

This block sits between a host register window and a set of child request handlers. A host write to the transmit window carries a 32-bit message. The low nibble of that message names the target channel. The message goes to the child on that channel in the same cycle when the child is idle. When the child is busy, the message waits in a shared deferral FIFO. Writes that cannot be routed are dropped and raise a one-cycle error pulse.

In the other direction, every child raises an available level while it holds a response. A priority collector moves those responses into a downstream receive mailbox. It moves one word per cycle, and the lowest-numbered channel always wins.

The host side uses valid/ready, with `tx_ready` tied high. Every presented write is consumed in the cycle it is offered: it is delivered, deferred or dropped. The receive side is also valid/ready, and `rx_ready` carries back-pressure from the mailbox, which drives it low when full. A response is pulled from a child only in a cycle where `rx_valid && rx_ready`. While `rx_ready` is low, `rx_valid` may switch to a lower-numbered channel whose response has just appeared.

Top module: `chan_mail_router`

## Requirements
- R1: A write is a transmit only when `tx_valid` is high, `tx_addr[7:4]` is 0xA and `tx_addr[1:0]` is 0, which covers offsets 0xA0, 0xA4, 0xA8 and 0xAC. A write to any other address drives no child and raises no error. `tx_ready` is always 1.
- R2: The target channel is `tx_data[3:0]`. A transmit whose channel is NUM_CH or higher is dropped, and `err_chan` is high for exactly the one cycle after it.
- R3: A transmit offered while the deferral FIFO holds DQ_DEPTH entries is dropped, and `err_full` is high for the one cycle after it. This check takes precedence over the channel check and over the busy state of the target. While it fires, `err_chan` stays low.
- R4: A transmit to a valid channel whose `ch_busy` bit is low, and that is not being fed from the FIFO in the same cycle, asserts that channel's `ch_wr_valid` bit in the same cycle. The full 32-bit value appears on its `ch_wr_data` slice (bits [32*c+31:32*c]).
- R5: A transmit to a busy child is stored whole in the deferral FIFO. The FIFO head is forwarded when its target child is idle, at most one entry per cycle, in arrival order. No child ever sees `ch_wr_valid` while its `ch_busy` is high.
- R6: Among channels with `ch_avail` high, the collector serves the lowest-numbered one first. It moves at most one response per cycle, and `ch_rd_strobe` is one-hot or zero.
- R7: While `rx_ready` is low, no valid response is pulled from any child and `ch_rd_strobe` stays zero.
- R8: A response equal to 0xFFFFFFFF (the invalid marker) is pulled and discarded regardless of `rx_ready`. It is never presented on `rx_valid`, and `err_resp` is high for the one cycle after it.
- R9: Reset empties the deferral FIFO and clears every error flag. Entries that were deferred before reset are never delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_valid | input | 1 | Host write strobe |
| tx_ready | output | 1 | Always 1; writes never stall |
| tx_addr | input | 8 | Low byte of the host register offset |
| tx_data | input | 32 | Host write value; bits 3:0 select the channel |
| ch_wr_valid | output | NUM_CH | Per-channel request strobe |
| ch_wr_data | output | 32*NUM_CH | Per-channel request word, 32-bit slice per channel |
| ch_busy | input | NUM_CH | Child still holds a pending request |
| ch_avail | input | NUM_CH | Child holds a response |
| ch_rd_strobe | output | NUM_CH | Pulls the current response from a child |
| ch_rd_data | input | 32*NUM_CH | Per-channel current response word |
| rx_valid | output | 1 | Response word offered to the receive mailbox |
| rx_ready | input | 1 | Receive mailbox has space |
| rx_data | output | 32 | Response word |
| err_full | output | 1 | Pulse: transmit dropped, FIFO full |
| err_chan | output | 1 | Pulse: transmit dropped, channel out of range |
| err_resp | output | 1 | Pulse: invalid-marker response discarded |

## Verification
The hardest state to reach is a full deferral FIFO that also receives writes aimed at an idle child and at an out-of-range channel. Only in that state does the precedence of the full check show. The bench holds one child busy, stacks exactly DQ_DEPTH messages behind it, and then offers the three kinds of overflow write before releasing the child. It also checks that exactly the stacked messages drain, in order. The collector order is set up the same way: the bench holds `rx_ready` low while several children raise responses together, then opens the mailbox and compares the drained sequence with the lowest-channel-first order.

// File: rtl/cmr_pkg.sv
package cmr_pkg;
  localparam int WORD_W = 32;
  localparam int CH_FIELD_W = 4;
  localparam logic [WORD_W-1:0] INVALID_WORD = 32'hFFFF_FFFF;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/cmr_defer_q.sv
module cmr_defer_q
  import cmr_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  push,
  input  word_t push_data,
  input  logic  pop,
  output word_t head,
  output logic  full,
  output logic  empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  word_t          slot [DEPTH];
  logic [AW-1:0]  wp, rp;
  logic [CW-1:0]  cnt;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) slot[i] <= INVALID_WORD;
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) begin
        slot[wp] <= push_data;
        wp       <= step(wp);
      end
      if (pop) begin
        slot[rp] <= INVALID_WORD;
        rp       <= step(rp);
      end
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  assign head  = slot[rp];
  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  p_head_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !empty |-> head != INVALID_WORD);
endmodule

// File: rtl/cmr_tx_route.sv
module cmr_tx_route
  import cmr_pkg::*;
#(
  parameter int NUM_CH = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tx_valid,
  input  logic [7:0]               tx_addr,
  input  word_t                    tx_data,
  input  logic [NUM_CH-1:0]        ch_busy,
  input  logic                     q_full,
  input  logic                     q_empty,
  input  word_t                    q_head,
  output logic                     q_push,
  output logic                     q_pop,
  output logic [NUM_CH-1:0]        wr_valid,
  output logic [NUM_CH*WORD_W-1:0] wr_data,
  output logic                     err_full_q,
  output logic                     err_chan_q
);
  logic                  is_tx, ch_ok, new_busy, hd_busy, direct, fwd;
  logic [CH_FIELD_W-1:0] tx_ch, hd_ch;

  assign tx_ch = tx_data[CH_FIELD_W-1:0];
  assign hd_ch = q_head[CH_FIELD_W-1:0];
  assign is_tx = tx_valid && (tx_addr[7:4] == 4'hA) && (tx_addr[1:0] == 2'b00);
  assign ch_ok = (int'(tx_ch) < NUM_CH);

  always_comb begin
    new_busy = 1'b1;
    hd_busy  = 1'b1;
    for (int i = 0; i < NUM_CH; i++) begin
      if (tx_ch == CH_FIELD_W'(i)) new_busy = ch_busy[i];
      if (hd_ch == CH_FIELD_W'(i)) hd_busy  = ch_busy[i];
    end
  end

  assign fwd    = !q_empty && !hd_busy;
  assign direct = is_tx && !q_full && ch_ok && !new_busy && !(fwd && (hd_ch == tx_ch));
  assign q_push = is_tx && !q_full && ch_ok && !direct;
  assign q_pop  = fwd;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
    localparam logic [CH_FIELD_W-1:0] CH_ID = CH_FIELD_W'(g);
    logic take_new, take_old;
    assign take_new    = direct && (tx_ch == CH_ID);
    assign take_old    = fwd && (hd_ch == CH_ID);
    assign wr_valid[g] = take_new || take_old;
    assign wr_data[g*WORD_W +: WORD_W] = take_new ? tx_data : q_head;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_full_q <= 1'b0;
      err_chan_q <= 1'b0;
    end else begin
      err_full_q <= is_tx && q_full;
      err_chan_q <= is_tx && !q_full && !ch_ok;
    end
  end

  p_busy_guard_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid & ch_busy) == '0);
  p_badch_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (is_tx && !ch_ok) |-> !q_push);
  p_one_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wr_valid) <= 2);
  p_full_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    err_full_q |-> !err_chan_q);
endmodule

// File: rtl/cmr_rsp_gather.sv
module cmr_rsp_gather
  import cmr_pkg::*;
#(
  parameter int NUM_CH = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CH-1:0]        ch_avail,
  input  logic [NUM_CH*WORD_W-1:0] ch_rd_data,
  output logic [NUM_CH-1:0]        ch_rd_strobe,
  output logic                     rx_valid,
  input  logic                     rx_ready,
  output word_t                    rx_data,
  output logic                     err_resp_q
);
  logic              any, bad, take;
  logic [NUM_CH-1:0] sel_oh;
  word_t             pick;

  always_comb begin
    any    = 1'b0;
    sel_oh = '0;
    pick   = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (ch_avail[i]) begin
        any       = 1'b1;
        sel_oh    = '0;
        sel_oh[i] = 1'b1;
        pick      = ch_rd_data[i*WORD_W +: WORD_W];
      end
    end
  end

  assign bad          = any && (pick == INVALID_WORD);
  assign take         = any && (rx_ready || bad);
  assign ch_rd_strobe = take ? sel_oh : '0;
  assign rx_valid     = any && !bad;
  assign rx_data      = pick;

  always_ff @(posedge clk) begin
    if (!rst_n) err_resp_q <= 1'b0;
    else        err_resp_q <= take && bad;
  end

  p_onehot_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_rd_strobe));
  p_lowest_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_rd_strobe != '0) |-> (((ch_rd_strobe - 1'b1) & ch_avail) == '0));
  p_hold_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |-> (ch_rd_strobe == '0));
  p_no_marker_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (rx_data != INVALID_WORD));
endmodule

// File: rtl/chan_mail_router.sv
module chan_mail_router
  import cmr_pkg::*;
#(
  parameter int NUM_CH   = 9,
  parameter int DQ_DEPTH = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tx_valid,
  output logic                     tx_ready,
  input  logic [7:0]               tx_addr,
  input  logic [WORD_W-1:0]        tx_data,
  output logic [NUM_CH-1:0]        ch_wr_valid,
  output logic [NUM_CH*WORD_W-1:0] ch_wr_data,
  input  logic [NUM_CH-1:0]        ch_busy,
  input  logic [NUM_CH-1:0]        ch_avail,
  output logic [NUM_CH-1:0]        ch_rd_strobe,
  input  logic [NUM_CH*WORD_W-1:0] ch_rd_data,
  output logic                     rx_valid,
  input  logic                     rx_ready,
  output logic [WORD_W-1:0]        rx_data,
  output logic                     err_full,
  output logic                     err_chan,
  output logic                     err_resp
);
  logic  q_push, q_pop, q_full, q_empty;
  word_t q_head;

  assign tx_ready = 1'b1;

  cmr_tx_route #(.NUM_CH(NUM_CH)) u_route (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_valid   (tx_valid),
    .tx_addr    (tx_addr),
    .tx_data    (tx_data),
    .ch_busy    (ch_busy),
    .q_full     (q_full),
    .q_empty    (q_empty),
    .q_head     (q_head),
    .q_push     (q_push),
    .q_pop      (q_pop),
    .wr_valid   (ch_wr_valid),
    .wr_data    (ch_wr_data),
    .err_full_q (err_full),
    .err_chan_q (err_chan)
  );

  cmr_defer_q #(.DEPTH(DQ_DEPTH)) u_defer (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (q_push),
    .push_data (tx_data),
    .pop       (q_pop),
    .head      (q_head),
    .full      (q_full),
    .empty     (q_empty)
  );

  cmr_rsp_gather #(.NUM_CH(NUM_CH)) u_gather (
    .clk          (clk),
    .rst_n        (rst_n),
    .ch_avail     (ch_avail),
    .ch_rd_data   (ch_rd_data),
    .ch_rd_strobe (ch_rd_strobe),
    .rx_valid     (rx_valid),
    .rx_ready     (rx_ready),
    .rx_data      (rx_data),
    .err_resp_q   (err_resp)
  );

  p_err_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_full && err_chan));
endmodule

// File: tb/chan_mail_router_tb_top.sv
`timescale 1ns/1ps
module chan_mail_router_tb_top;
  localparam int N  = 9;
  localparam int DQ = 4;
  localparam logic [31:0] MARK = 32'hFFFF_FFFF;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            tx_valid;
  logic            tx_ready;
  logic [7:0]      tx_addr;
  logic [31:0]     tx_data;
  logic [N-1:0]    ch_wr_valid;
  logic [N*32-1:0] ch_wr_data;
  logic [N-1:0]    ch_busy;
  logic [N-1:0]    ch_avail;
  logic [N-1:0]    ch_rd_strobe;
  logic [N*32-1:0] ch_rd_data;
  logic            rx_valid;
  logic            rx_ready;
  logic [31:0]     rx_data;
  logic            err_full, err_chan, err_resp;

  int checks = 0;
  int errors = 0;
  int wr_seen = 0;
  int rx_seen = 0;
  logic [35:0] wexp[$];
  logic [31:0] rexp[$];
  int   given [N];
  int   taken [N];
  logic bad_flag [N];

  always #2 clk = ~clk;

  chan_mail_router #(.NUM_CH(N), .DQ_DEPTH(DQ)) dut_i (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_addr(tx_addr), .tx_data(tx_data), .ch_wr_valid(ch_wr_valid),
    .ch_wr_data(ch_wr_data), .ch_busy(ch_busy), .ch_avail(ch_avail),
    .ch_rd_strobe(ch_rd_strobe), .ch_rd_data(ch_rd_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .err_full(err_full),
    .err_chan(err_chan), .err_resp(err_resp)
  );

  function automatic logic [31:0] rsp_word(input int ch, input int seq);
    return {8'hA5, 8'(ch), 16'(seq)};
  endfunction

  always_comb begin
    for (int i = 0; i < N; i++) begin
      ch_avail[i] = (given[i] != taken[i]);
      ch_rd_data[i*32 +: 32] = bad_flag[i] ? MARK : rsp_word(i, taken[i]);
    end
  end

  always @(posedge clk) begin
    for (int i = 0; i < N; i++)
      if (ch_rd_strobe[i] && ch_avail[i]) taken[i] <= taken[i] + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor for child writes and mailbox responses
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < N; i++) begin
        if (ch_wr_valid[i]) begin
          int  idx;
          idx = -1;
          wr_seen++;
          for (int k = 0; k < wexp.size(); k++)
            if (idx < 0 && wexp[k][35:32] == 4'(i)) idx = k;
          if (idx < 0) begin
            chk(1'b0, "R5", "unexpected child write", ch_wr_data[i*32 +: 32], 32'(i));
          end else begin
            chk(ch_wr_data[i*32 +: 32] == wexp[idx][31:0], "R4",
                "child write data", ch_wr_data[i*32 +: 32], wexp[idx][31:0]);
            wexp.delete(idx);
          end
        end
      end
      if (rx_valid && rx_ready) begin
        rx_seen++;
        if (rexp.size() == 0) chk(1'b0, "R6", "unexpected response", rx_data, 32'h0);
        else begin
          logic [31:0] e;
          e = rexp.pop_front();
          chk(rx_data == e, "R6", "response order", rx_data, e);
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    tx_valid = 1'b1; tx_addr = a; tx_data = d;
    @(posedge clk); #1;
    tx_valid = 1'b0;
  endtask

  task automatic expect_wr(input int ch, input logic [31:0] d);
    wexp.push_back({4'(ch), d});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int base;
    rst_n = 1'b0; tx_valid = 1'b0; tx_addr = '0; tx_data = '0;
    ch_busy = '0; rx_ready = 1'b0;
    for (int i = 0; i < N; i++) begin given[i] = 0; taken[i] = 0; bad_flag[i] = 1'b0; end
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R9 reset state, R1 ready
    chk(tx_ready == 1'b1, "R1", "tx_ready", 32'(tx_ready), 32'd1);
    chk(ch_wr_valid == '0 && rx_valid == 1'b0, "R9", "idle outputs", 32'(ch_wr_valid), 32'd0);
    chk({err_full, err_chan, err_resp} == 3'b0, "R9", "error flags", 32'({err_full, err_chan, err_resp}), 32'd0);

    // R4 direct delivery to idle child
    expect_wr(2, 32'h1234_5672);
    send(8'hA0, 32'h1234_5672);
    chk(!err_full && !err_chan, "R4", "no error on direct", 32'({err_full, err_chan}), 32'd0);
    tick(2);
    chk(wexp.size() == 0, "R4", "direct delivered", 32'(wexp.size()), 32'd0);

    // R1 window decode
    expect_wr(0, 32'hCAFE_0000);
    send(8'hA4, 32'hCAFE_0000);
    expect_wr(8, 32'h0000_0018);
    send(8'hAC, 32'h0000_0018);
    tick(2);
    base = wr_seen;
    send(8'h90, 32'h0000_0001);
    send(8'hB0, 32'h0000_0001);
    send(8'hA2, 32'h0000_0001);
    chk(!err_full && !err_chan, "R1", "outside window no error", 32'({err_full, err_chan}), 32'd0);
    tick(2);
    chk(wr_seen == base && wexp.size() == 0, "R1", "outside window ignored", 32'(wr_seen - base), 32'd0);

    // R2 invalid channel
    send(8'hA8, 32'hDEAD_0009);
    chk(err_chan == 1'b1 && err_full == 1'b0, "R2", "err_chan on 9", 32'(err_chan), 32'd1);
    tick(1);
    chk(err_chan == 1'b0, "R2", "err_chan one cycle", 32'(err_chan), 32'd0);
    send(8'hA0, 32'hDEAD_000F);
    chk(err_chan == 1'b1, "R2", "err_chan on 15", 32'(err_chan), 32'd1);
    tick(2);
    chk(wr_seen == base, "R2", "invalid channel dropped", 32'(wr_seen - base), 32'd0);

    // R5 deferral behind a busy child
    ch_busy[4] = 1'b1;
    expect_wr(4, 32'h4444_0004);
    send(8'hA0, 32'h4444_0004);
    expect_wr(4, 32'h5555_0004);
    send(8'hA0, 32'h5555_0004);
    expect_wr(2, 32'h2222_0002);
    send(8'hA0, 32'h2222_0002);
    tick(4);
    chk(wr_seen == base + 1, "R5", "held while busy", 32'(wr_seen - base), 32'd1);
    ch_busy[4] = 1'b0;
    tick(4);
    chk(wexp.size() == 0 && wr_seen == base + 3, "R5", "deferred drained in order", 32'(wr_seen - base), 32'd3);

    // R3 full deferral FIFO
    base = wr_seen;
    ch_busy[1] = 1'b1;
    for (int k = 0; k < DQ; k++) begin
      expect_wr(1, 32'h1000_0001 | (32'(k) << 8));
      send(8'hA4, 32'h1000_0001 | (32'(k) << 8));
      chk(!err_full, "R3", "no error while filling", 32'(err_full), 32'd0);
    end
    send(8'hA4, 32'h1F00_0001);
    chk(err_full == 1'b1, "R3", "full drop busy target", 32'(err_full), 32'd1);
    send(8'hA4, 32'h1F00_0000);
    chk(err_full == 1'b1, "R3", "full drop idle target", 32'(err_full), 32'd1);
    send(8'hA4, 32'h1F00_000A);
    chk(err_full == 1'b1 && err_chan == 1'b0, "R3", "full precedes channel check",
        32'({err_full, err_chan}), 32'b10);
    chk(wr_seen == base, "R3", "nothing delivered while full", 32'(wr_seen - base), 32'd0);
    ch_busy[1] = 1'b0;
    tick(6);
    chk(wexp.size() == 0 && wr_seen == base + DQ, "R3", "only stored entries drain",
        32'(wr_seen - base), 32'(DQ));

    // R6/R7 collector priority and back-pressure
    base = rx_seen;
    rx_ready = 1'b0;
    given[5] += 2; given[1] += 1; given[0] += 2;
    rexp.push_back(rsp_word(0, 0)); rexp.push_back(rsp_word(0, 1));
    rexp.push_back(rsp_word(1, 0));
    rexp.push_back(rsp_word(5, 0)); rexp.push_back(rsp_word(5, 1));
    tick(4);
    chk(ch_avail == 9'b000100011 && rx_seen == base, "R7", "nothing pulled while blocked",
        32'(ch_avail), 32'h23);
    chk(ch_rd_strobe == '0, "R7", "strobe low while blocked", 32'(ch_rd_strobe), 32'd0);
    rx_ready = 1'b1;
    tick(2);
    chk(rx_seen == base + 2, "R6", "one response per cycle", 32'(rx_seen - base), 32'd2);
    tick(6);
    chk(rexp.size() == 0 && rx_seen == base + 5, "R6", "all responses drained",
        32'(rx_seen - base), 32'd5);

    // R8 invalid marker response
    base = rx_seen;
    bad_flag[3] = 1'b1;
    given[3] += 1;
    tick(1);
    chk(err_resp == 1'b1, "R8", "err_resp on marker", 32'(err_resp), 32'd1);
    chk(ch_avail[3] == 1'b0 && rx_seen == base, "R8", "marker discarded", 32'(rx_seen - base), 32'd0);
    bad_flag[3] = 1'b0;
    rexp.push_back(rsp_word(3, 1));
    given[3] += 1;
    tick(3);
    chk(rexp.size() == 0 && err_resp == 1'b0, "R8", "good response after marker",
        32'(rexp.size()), 32'd0);

    // R9 reset drops deferred entries
    base = wr_seen;
    ch_busy[6] = 1'b1;
    send(8'hA0, 32'h6666_0006);
    rst_n = 1'b0;
    tick(2);
    rst_n = 1'b1;
    ch_busy[6] = 1'b0;
    tick(5);
    chk(wr_seen == base, "R9", "deferred entry lost on reset", 32'(wr_seen - base), 32'd0);
    chk({err_full, err_chan, err_resp} == 3'b0, "R9", "errors clear after reset",
        32'({err_full, err_chan, err_resp}), 32'd0);

    chk(wexp.size() == 0 && rexp.size() == 0, "R5", "scoreboard empty",
        32'(wexp.size() + rexp.size()), 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule